// File: doc/BRIEF.md
# Chip-Select Output Set/Clear Unit

This unit owns a bank of output pins that can serve as chip selects for a serial peripheral bus or as plain general-purpose outputs. Each pin has a stored latch bit. Software changes any group of latches with a single set/clear word: the upper half of the word names the latches to raise, and the lower half names the latches to drop. Latches whose bits are zero in both halves keep their value, so no read-modify-write is needed.

A configuration word assigns chip-select duty to each pin and can invert each pin's output. The pin level is the latch value XOR the invert bit. This lets the same convention serve active-low and active-high devices: a cleared latch always means "selected".

A hardware select port carries a chip-select number and an assert/deassert flag. The number is mapped to a pin index by subtracting a base (parameter, default 1). Numbers below the base, and numbers past the last pin, are ignored. A request only affects a pin that is marked for chip-select duty.

Top module: `cs_gpo_unit`

## Requirements
- R1: After reset, every latch is 0, the configuration is 0, and every pin output is 0.
- R2: On a set/clear write, each 1 in bits 15:8 sets the latch of pin (bit − 8) from the next clock edge on.
- R3: On a set/clear write, each 1 in bits 7:0 clears the latch of the pin with the same index.
- R4: A latch whose set and clear bits are both 0 keeps its value, including on cycles with no write at all.
- R5: When the set bit and the clear bit of one pin are both 1 in the same write, the latch is cleared.
- R6: Each pin output equals its latch XOR bit i of the configuration word (bits 7:0 are the invert controls); `latch_o` shows the raw latches.
- R7: A select request for number n drives pin n − BASE only when configuration bit 8 + (n − BASE) (the chip-select duty bit) is 1. With `sel_assert_i` = 1 the request clears the latch; with `sel_assert_i` = 0 it sets the latch.
- R8: A select request whose number is below BASE, or at or above BASE + NPIN, changes no latch.
- R9: A set/clear write and a select request in the same cycle are merged bit by bit, and a clear from either source wins over a set.
- R10: A configuration write changes the pin polarity and duty bits only; it leaves every latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 2*NPIN | Chip-select duty bits in the upper half, invert bits in the lower half |
| sc_we_i | input | 1 | Set/clear write strobe |
| sc_wdata_i | input | 2*NPIN | Set bits in the upper half, clear bits in the lower half |
| sel_we_i | input | 1 | Hardware select request strobe |
| sel_num_i | input | NUM_W | Chip-select number of the request |
| sel_assert_i | input | 1 | 1: select (clear the latch); 0: deselect (set the latch) |
| pin_o | output | NPIN | Pin levels |
| latch_o | output | NPIN | Current latch values |

## Verification
The bench targets four cases. First, a write with both set and clear bits for one pin: a design that lets set win would leave that latch high. Second, all-zero bits in a write: a design that loads the word directly would wipe latches that were meant to stay. Third, select numbers just outside the range, 0 and BASE + NPIN: an index computed with wrap-around would hit pin 7 or pin 0. Fourth, a request to a pin without chip-select duty, and a same-cycle collision of a set/clear write with a select request: a design with the wrong priority would leave the selected pin deselected. Inversion is also checked against the raw latches, so a design that applies the invert before storing the latch would show the error on `latch_o`.

// File: rtl/cs_gpo_pkg.sv
package cs_gpo_pkg;
  typedef enum logic {
    CS_RELEASE = 1'b0,
    CS_SELECT  = 1'b1
  } cs_action_e;

  function automatic logic [7:0] merge_masks(input logic [7:0] a, input logic [7:0] b);
    return a | b;
  endfunction
endpackage

// File: rtl/cs_sel_decode.sv
module cs_sel_decode #(
  parameter int NPIN  = 8,
  parameter int NUM_W = 4,
  parameter int BASE  = 1
) (
  input  logic             sel_we_i,
  input  logic [NUM_W-1:0] sel_num_i,
  input  logic             sel_assert_i,
  input  logic [NPIN-1:0]  cs_mode_i,
  output logic [NPIN-1:0]  set_o,
  output logic [NPIN-1:0]  clr_o
);
  import cs_gpo_pkg::*;

  localparam int IDX_W = NUM_W + 1;
  localparam logic [IDX_W-1:0] BASE_V = IDX_W'(BASE);
  localparam logic [IDX_W-1:0] LAST_V = IDX_W'(BASE + NPIN);

  logic [IDX_W-1:0] num_ext;
  logic [IDX_W-1:0] idx;
  logic             in_range;
  cs_action_e       act;

  assign num_ext  = {1'b0, sel_num_i};
  assign idx      = num_ext - BASE_V;
  assign in_range = sel_we_i && (num_ext >= BASE_V) && (num_ext < LAST_V);
  assign act      = cs_action_e'(sel_assert_i);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic hit;
    assign hit      = in_range && (idx == IDX_W'(i)) && cs_mode_i[i];
    assign set_o[i] = hit && (act == CS_RELEASE);
    assign clr_o[i] = hit && (act == CS_SELECT);
  end
endmodule

// File: rtl/cs_latch_bank.sv
module cs_latch_bank #(
  parameter int NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] set_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] q_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (clr_i[i]) q_o[i] <= 1'b0;   // clear has priority
      else if (set_i[i]) q_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/cs_gpo_unit.sv
module cs_gpo_unit #(
  parameter int NPIN  = 8,
  parameter int NUM_W = 4,
  parameter int BASE  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2*NPIN-1:0] cfg_wdata_i,
  input  logic              sc_we_i,
  input  logic [2*NPIN-1:0] sc_wdata_i,
  input  logic              sel_we_i,
  input  logic [NUM_W-1:0]  sel_num_i,
  input  logic              sel_assert_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   latch_o
);
  localparam int WW = 2 * NPIN;

  logic [WW-1:0]   cfg_q;
  logic [NPIN-1:0] cs_mode, inv;
  logic [NPIN-1:0] sc_set, sc_clr, sel_set, sel_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  assign cs_mode = cfg_q[WW-1:NPIN];
  assign inv     = cfg_q[NPIN-1:0];
  assign sc_set  = sc_we_i ? sc_wdata_i[WW-1:NPIN] : '0;
  assign sc_clr  = sc_we_i ? sc_wdata_i[NPIN-1:0]  : '0;

  cs_sel_decode #(.NPIN(NPIN), .NUM_W(NUM_W), .BASE(BASE)) u_dec (
    .sel_we_i    (sel_we_i),
    .sel_num_i   (sel_num_i),
    .sel_assert_i(sel_assert_i),
    .cs_mode_i   (cs_mode),
    .set_o       (sel_set),
    .clr_o       (sel_clr)
  );

  cs_latch_bank #(.NPIN(NPIN)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sc_set | sel_set),
    .clr_i (sc_clr | sel_clr),
    .q_o   (latch_o)
  );

  assign pin_o = latch_o ^ inv;
endmodule

// File: rtl/cs_gpo_unit_chk.sv
module cs_gpo_unit_chk #(
  parameter int NPIN  = 8,
  parameter int NUM_W = 4,
  parameter int BASE  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              sc_we_i,
  input logic [2*NPIN-1:0] sc_wdata_i,
  input logic              sel_we_i,
  input logic [NUM_W-1:0]  sel_num_i,
  input logic [NPIN-1:0]   latch_o
);
  localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);

  logic [NPIN-1:0] set_only, clr_bits, both;
  assign clr_bits = sc_wdata_i[NPIN-1:0];
  assign set_only = sc_wdata_i[2*NPIN-1:NPIN] & ~clr_bits;
  assign both     = sc_wdata_i[2*NPIN-1:NPIN] & clr_bits;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_we_i && !sel_we_i) |=> ((latch_o & $past(set_only)) == $past(set_only)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_we_i |=> ((latch_o & $past(clr_bits)) == '0));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sc_we_i && !sel_we_i) |=> $stable(latch_o));

  p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_we_i && (|both)) |=> ((latch_o & $past(both)) == '0));

  p_low_num_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && (sel_num_i < BASE_N) && !sc_we_i) |=> $stable(latch_o));

  p_cfg_keeps_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !sc_we_i && !sel_we_i) |=> $stable(latch_o));
endmodule

bind cs_gpo_unit cs_gpo_unit_chk #(.NPIN(NPIN), .NUM_W(NUM_W), .BASE(BASE)) u_chk (.*);

// File: tb/cs_gpo_unit_tb_top.sv
module cs_gpo_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        sc_we_i = 1'b0;
  logic [15:0] sc_wdata_i = '0;
  logic        sel_we_i = 1'b0;
  logic [3:0]  sel_num_i = '0;
  logic        sel_assert_i = 1'b0;
  logic [7:0]  pin_o, latch_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  cs_gpo_unit dut_i (.*);

  // {set/clear word, expected latches after it}, configuration all zero
  localparam logic [23:0] VEC [8] = '{
    {16'hFF00, 8'hFF},  // R2
    {16'h0001, 8'hFE},  // R3
    {16'h0000, 8'hFE},  // R4
    {16'h00F0, 8'h0E},  // R3
    {16'h0303, 8'h0C},  // R5
    {16'h1100, 8'h1D},  // R2 R4
    {16'h8040, 8'h9D},  // R2 R3
    {16'h00FF, 8'h00}   // R3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sc_write(input logic [15:0] w);
    @(negedge clk_i); sc_we_i = 1'b1; sc_wdata_i = w;
    @(negedge clk_i); sc_we_i = 1'b0; sc_wdata_i = '0;
  endtask

  task automatic cfg_write(input logic [15:0] w);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = w;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic sel_req(input logic [3:0] n, input logic a);
    @(negedge clk_i); sel_we_i = 1'b1; sel_num_i = n; sel_assert_i = a;
    @(negedge clk_i); sel_we_i = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 latch", latch_o, 8'h00);
    check("R1 pin", pin_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 8; i++) begin
      sc_write(VEC[i][23:8]);
      check($sformatf("R2/R3/R4/R5 vec%0d", i), latch_o, VEC[i][7:0]);
      check($sformatf("R6 vec%0d pin", i), pin_o, VEC[i][7:0]);
    end

    // R10: configuration write leaves latches alone; R6 inversion
    cfg_write(16'hFF0F);
    check("R10 latch", latch_o, 8'h00);
    check("R6 inverted pin", pin_o, 8'h0F);
    sc_write(16'hFF00);
    check("R6 latch raw", latch_o, 8'hFF);
    check("R6 pin", pin_o, 8'hF0);

    // R7 select/release via hardware port
    sel_req(4'd1, 1'b1);
    check("R7 select n1", latch_o, 8'hFE);
    check("R7 select n1 pin", pin_o, 8'hF1);
    sel_req(4'd1, 1'b0);
    check("R7 release n1", latch_o, 8'hFF);
    sel_req(4'd8, 1'b1);
    check("R7 select n8", latch_o, 8'h7F);

    // R8 out-of-range numbers
    sel_req(4'd0, 1'b1);
    check("R8 below base", latch_o, 8'h7F);
    sel_req(4'd9, 1'b1);
    check("R8 past last", latch_o, 8'h7F);
    sel_req(4'd15, 1'b0);
    check("R8 max num", latch_o, 8'h7F);

    // R7 pin without chip-select duty ignores requests
    cfg_write(16'h000F);
    sel_req(4'd2, 1'b1);
    check("R7 no duty", latch_o, 8'h7F);

    // R9 collision: set from word, select from port on the same pin
    cfg_write(16'hFF00);
    @(negedge clk_i);
    sc_we_i = 1'b1; sc_wdata_i = 16'h8200;
    sel_we_i = 1'b1; sel_num_i = 4'd2; sel_assert_i = 1'b1;
    @(negedge clk_i);
    sc_we_i = 1'b0; sel_we_i = 1'b0;
    check("R9 merge clear wins", latch_o, 8'hFD);

    // R4 idle cycles hold
    repeat (3) @(negedge clk_i);
    check("R4 idle hold", latch_o, 8'hFD);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule